// File: doc/BRIEF.md
# Disk Controller Threshold Data FIFO

This block is the data buffer between the host data port of a floppy-style disk controller and its serial disk data path. The host reads and writes one data register, paced by a request-for-master flag, a direction flag and a DMA request. The disk side moves one byte per strobe at the selected data rate. After reset, and whenever no execution phase is running, the buffer holds a single byte, as a plain data register would. A configuration strobe can turn on full 16-byte operation with a programmable service threshold. That setting applies only while a command is executing.

Entering the execution phase flushes the buffer so that no stale bytes move. If the disk produces a byte with no room left (read overrun), or asks for a byte that is not there (write underrun), the command is aborted and the flow of data stops. After an overrun the host must still drain the buffered bytes before the result phase is flagged. After an underrun the block pads the rest of the sector with zero bytes and, at the end of the sector, tells the CRC stage to append a valid CRC.

A service-delay monitor measures how long a DMA request waits without service. It compares that wait with the threshold times one byte time at the selected rate, less a fixed guard of 1.5 µs.

Top module: `fdc_data_fifo`

## Requirements
- R1: After reset the FIFO is disabled and the threshold is 1. The buffer is empty, `dma_req` is 0, and all of `overrun`, `underrun`, `cmd_abort`, `pad_active`, `crc_append`, `result_ready` and `latency_viol` are 0.
- R2: A `cfg_load` pulse stores `cfg_fifo_en` and `cfg_thresh`. A threshold of 0 is stored as 1. With the FIFO enabled and `exec_active` high, the buffer holds 16 bytes and the threshold takes effect.
- R3: While `exec_active` is 0, or while the FIFO is disabled, the buffer holds one byte and the threshold is 1. A second host write to a full buffer is ignored.
- R4: `dio` equals `dir_read` (1 = controller to host). When `dir_read`=1, `rqm` is 1 while the buffer holds data. When `dir_read`=0, `rqm` is 1 while there is room and the transfer has not been stopped.
- R5: An `exec_start` pulse empties the buffer and clears `overrun`, `underrun`, `pad_active` and `latency_viol` on the next clock edge.
- R6: Bytes leave in the order they entered. `host_rdata` shows the oldest byte, and `dsk_out` shows the byte taken by the most recent `dsk_take` from the edge that took it.
- R7: During execution with no error, `dma_req` is 1 when the buffer count is at least the threshold (read) or below the threshold (write). Otherwise it is 0.
- R8: A `dsk_put` to a full buffer during execution sets `overrun` and drops the byte. `cmd_abort` pulses for one cycle and `dma_req` falls. Further disk bytes are ignored, the host can still drain the buffer, and `result_ready` is 1 once it is empty.
- R9: A `dsk_take` from an empty buffer during a write execution sets `underrun` and `pad_active` and pulses `cmd_abort`. That take and every later one give `dsk_out`=0x00, and host writes are ignored with `rqm`=0.
- R10: A `sector_end` while `pad_active` is 1 pulses `crc_append` for one cycle and clears `pad_active`.
- R11: `rate_sel` 2'b10 selects 2 Mbps, 2'b01 selects 1 Mbps, and any other value selects 500 kbps. A byte is 400, 800 or 1600 clocks. `latency_viol` sets after `dma_req` has stayed high without a host transfer for threshold × byte clocks − 150 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Store FIFO enable and threshold |
| cfg_fifo_en | input | 1 | FIFO enable value |
| cfg_thresh | input | 4 | Service threshold value (0 stored as 1) |
| rate_sel | input | 2 | Disk data rate select |
| exec_start | input | 1 | Entry to the execution phase; flushes the buffer |
| exec_active | input | 1 | Execution phase in progress |
| dir_read | input | 1 | 1 = disk read (controller to host) |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Oldest buffered byte |
| rqm | output | 1 | Host may access the data register |
| dio | output | 1 | Transfer direction flag |
| dma_req | output | 1 | DMA service request |
| dsk_put | input | 1 | Disk delivers a byte (read) |
| dsk_in | input | 8 | Disk byte in |
| dsk_take | input | 1 | Disk consumes a byte (write) |
| dsk_out | output | 8 | Byte given to the disk |
| sector_end | input | 1 | Current sector finished on the disk side |
| overrun | output | 1 | Read overrun seen |
| underrun | output | 1 | Write underrun seen |
| cmd_abort | output | 1 | One-cycle command termination pulse |
| pad_active | output | 1 | Zero padding of the sector in progress |
| crc_append | output | 1 | One-cycle request to append a valid CRC |
| result_ready | output | 1 | Overrun drained; result phase may begin |
| latency_viol | output | 1 | Service delay limit exceeded |

## Verification
The bench fills the buffer to exactly 16 and then adds one byte more. A design that accepted the extra byte, or refused to let the host drain after the abort, would corrupt the drained sequence or never raise `result_ready`. It runs the write side into an empty buffer and checks that the taken byte is 0x00, not a stale byte, and that later host writes stay out. It checks that the flush on `exec_start` removes a byte left over from the command phase. It also checks that a threshold of 0 behaves as 1. The latency monitor is checked just before and just after its limit, so an off-by-one byte time or a wrong rate shift would show.

// File: rtl/fdc_fifo_pkg.sv
package fdc_fifo_pkg;

    typedef enum logic [1:0] {
        RATE_500K = 2'b00,
        RATE_1M   = 2'b01,
        RATE_2M   = 2'b10,
        RATE_RSVD = 2'b11
    } rate_e;

    // Left shift applied to the 2 Mbps byte time for each rate.
    function automatic logic [1:0] rate_shift(input logic [1:0] sel);
        case (rate_e'(sel))
            RATE_2M: rate_shift = 2'd0;
            RATE_1M: rate_shift = 2'd1;
            default: rate_shift = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/fdc_fifo_store.sv
module fdc_fifo_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wp_inc, rp_inc;

    localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

    generate
        if (POW2) begin : g_wrap_free
            assign wp_inc = st_q.wp + 1'b1;
            assign rp_inc = st_q.rp + 1'b1;
        end else begin : g_wrap_cmp
            assign wp_inc = (st_q.wp == PTR_W'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            assign rp_inc = (st_q.rp == PTR_W'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push) st_d.wp = wp_inc;
            if (pop)  st_d.rp = rp_inc;
            case ({push, pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem_q[st_q.wp] <= wdata;
    end

    assign head  = mem_q[st_q.rp];
    assign count = st_q.cnt;

    // R12-style guard: the controller never pushes into a full store.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush) |-> (count < CNT_W'(DEPTH)));
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> (count != '0));

endmodule

// File: rtl/fdc_service_timer.sv
module fdc_service_timer
    import fdc_fifo_pkg::*;
#(
    parameter int THR_W        = 4,
    parameter int BYTE_CLKS_2M = 400,
    parameter int GUARD_CLKS   = 150,
    localparam int LIM_W = $clog2(((1 << THR_W) * BYTE_CLKS_2M * 4) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             serviced,
    input  logic [THR_W-1:0] thr,
    input  logic [1:0]       rate_sel,
    output logic             viol
);

    typedef struct packed {
        logic [LIM_W-1:0] cnt;
        logic             viol;
    } tm_t;

    tm_t tm_d, tm_q;
    logic [LIM_W-1:0] byte_clks, limit;

    always_comb begin
        byte_clks = LIM_W'(BYTE_CLKS_2M) << rate_shift(rate_sel);
        limit     = LIM_W'(thr) * byte_clks - LIM_W'(GUARD_CLKS);
        tm_d      = tm_q;
        if (clear) begin
            tm_d = '0;
        end else if (!run || serviced) begin
            tm_d.cnt = '0;
        end else if (tm_q.cnt != limit) begin
            tm_d.cnt = tm_q.cnt + 1'b1;
            if (tm_q.cnt == limit - 1'b1) tm_d.viol = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign viol = tm_q.viol;

    assert_viol_needs_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol) |-> ($past(run) && !$past(serviced)));

endmodule

// File: rtl/fdc_data_fifo.sv
module fdc_data_fifo
    import fdc_fifo_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int DATA_W       = 8,
    parameter int BYTE_CLKS_2M = 400,
    parameter int GUARD_CLKS   = 150,
    localparam int THR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_fifo_en,
    input  logic [THR_W-1:0]  cfg_thresh,
    input  logic [1:0]        rate_sel,
    input  logic              exec_start,
    input  logic              exec_active,
    input  logic              dir_read,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              rqm,
    output logic              dio,
    output logic              dma_req,
    input  logic              dsk_put,
    input  logic [DATA_W-1:0] dsk_in,
    input  logic              dsk_take,
    output logic [DATA_W-1:0] dsk_out,
    input  logic              sector_end,
    output logic              overrun,
    output logic              underrun,
    output logic              cmd_abort,
    output logic              pad_active,
    output logic              crc_append,
    output logic              result_ready,
    output logic              latency_viol
);

    typedef struct packed {
        logic              fifo_en;
        logic [THR_W-1:0]  thr;
        logic              ovr;
        logic              und;
        logic              pad;
        logic              abort;
        logic              crc;
        logic [DATA_W-1:0] dout;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              push, pop, full, empty, stopped, wide;
    logic              ovr_evt, und_evt;
    logic [CNT_W-1:0]  count, cap_eff;
    logic [THR_W-1:0]  thr_eff;
    logic [DATA_W-1:0] head, push_data;

    fdc_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (exec_start),
        .push  (push),
        .pop   (pop),
        .wdata (push_data),
        .head  (head),
        .count (count)
    );

    always_comb begin
        wide      = exec_active && ctl_q.fifo_en;
        cap_eff   = wide ? CNT_W'(DEPTH) : CNT_W'(1);
        thr_eff   = wide ? ctl_q.thr : THR_W'(1);
        full      = (count >= cap_eff);
        empty     = (count == '0);
        stopped   = exec_active && (ctl_q.ovr || ctl_q.und);
        push_data = dir_read ? dsk_in : host_wdata;

        push    = 1'b0;
        pop     = 1'b0;
        ovr_evt = 1'b0;
        und_evt = 1'b0;
        if (!exec_start) begin
            if (dir_read) begin
                push    = dsk_put && !full && !stopped;
                pop     = host_rd && !empty;
                ovr_evt = exec_active && dsk_put && full && !stopped;
            end else begin
                push    = host_wr && !full && !stopped;
                pop     = dsk_take && !empty && !ctl_q.pad;
                und_evt = exec_active && dsk_take && empty && !stopped;
            end
        end

        ctl_d       = ctl_q;
        ctl_d.abort = ovr_evt || und_evt;
        ctl_d.crc   = 1'b0;
        if (cfg_load) begin
            ctl_d.fifo_en = cfg_fifo_en;
            ctl_d.thr     = (cfg_thresh == '0) ? THR_W'(1) : cfg_thresh;
        end
        if (!dir_read && dsk_take) ctl_d.dout = pop ? head : '0;
        if (exec_start) begin
            ctl_d.ovr = 1'b0;
            ctl_d.und = 1'b0;
            ctl_d.pad = 1'b0;
        end else begin
            if (ovr_evt) ctl_d.ovr = 1'b1;
            if (und_evt) begin
                ctl_d.und = 1'b1;
                ctl_d.pad = 1'b1;
            end else if (ctl_q.pad && sector_end) begin
                ctl_d.pad = 1'b0;
                ctl_d.crc = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.thr <= THR_W'(1);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign host_rdata   = head;
    assign dio          = dir_read;
    assign rqm          = dir_read ? !empty : (!full && !stopped);
    assign dma_req      = exec_active && !stopped &&
                          (dir_read ? (count >= CNT_W'(thr_eff)) : (count < CNT_W'(thr_eff)));
    assign dsk_out      = ctl_q.dout;
    assign overrun      = ctl_q.ovr;
    assign underrun     = ctl_q.und;
    assign cmd_abort    = ctl_q.abort;
    assign pad_active   = ctl_q.pad;
    assign crc_append   = ctl_q.crc;
    assign result_ready = ctl_q.ovr && empty;

    fdc_service_timer #(
        .THR_W(THR_W), .BYTE_CLKS_2M(BYTE_CLKS_2M), .GUARD_CLKS(GUARD_CLKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (exec_start),
        .run      (dma_req),
        .serviced (host_wr || host_rd),
        .thr      (thr_eff),
        .rate_sel (rate_sel),
        .viol     (latency_viol)
    );

    assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> (count == '0));
    assert_abort_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_abort |=> !cmd_abort);
    assert_pad_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_active && dsk_take && !dir_read && !exec_start) |=> (dsk_out == '0));
    assert_crc_after_pad_R10: assert property (@(posedge clk) disable iff (!rst_n)
        crc_append |-> $past(pad_active));
    assert_result_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (result_ready && dir_read) |-> !rqm);

endmodule

// File: tb/sim_fdc_data_fifo.sv
module sim_fdc_data_fifo;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 0, cfg_fifo_en = 0;
    logic [3:0] cfg_thresh = 0;
    logic [1:0] rate_sel = 2'b00;
    logic exec_start = 0, exec_active = 0, dir_read = 0;
    logic host_wr = 0, host_rd = 0, dsk_put = 0, dsk_take = 0, sector_end = 0;
    logic [7:0] host_wdata = 0, dsk_in = 0;
    logic [7:0] host_rdata, dsk_out;
    logic rqm, dio, dma_req, overrun, underrun, cmd_abort, pad_active;
    logic crc_append, result_ready, latency_viol;

    int errors = 0;
    int checks = 0;
    logic [7:0] mq[$];

    always #5 clk = ~clk;

    fdc_data_fifo u0 (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        host_wr = 0; host_rd = 0; dsk_put = 0; dsk_take = 0;
        sector_end = 0; cfg_load = 0; exec_start = 0;
    endtask

    task automatic configure(input bit en, input logic [3:0] thr);
        cfg_load = 1; cfg_fifo_en = en; cfg_thresh = thr;
        cyc();
        cfg_load = 0;
    endtask

    task automatic start_exec(input bit rd);
        dir_read = rd; exec_active = 1; exec_start = 1;
        cyc();
        exec_start = 0;
        mq.delete();
    endtask

    function automatic bit exp_dma(input bit rd, input int cnt, input int thr);
        return rd ? (cnt >= thr) : (cnt < thr);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        #2;
        cyc(); cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        check(dma_req == 0 && overrun == 0 && underrun == 0 && cmd_abort == 0, "R1", "flags", 0, 0);
        check(pad_active == 0 && crc_append == 0 && result_ready == 0 && latency_viol == 0, "R1", "flags2", 0, 0);
        check(rqm == 1 && dio == 0, "R4", "idle rqm/dio", {rqm, dio}, 2'b10);

        // R3: outside execution one byte at a time
        host_wr = 1; host_wdata = 8'hA5; cyc();
        check(rqm == 0, "R3", "rqm after one byte", rqm, 0);
        host_wdata = 8'h3C; cyc();
        host_wr = 0; dsk_take = 1; cyc(); dsk_take = 0;
        check(dsk_out == 8'hA5, "R3", "second write ignored", dsk_out, 8'hA5);
        check(rqm == 1, "R3", "rqm after take", rqm, 1);

        // R5: stale byte from command phase is flushed
        dir_read = 1; dsk_put = 1; dsk_in = 8'h77; cyc(); dsk_put = 0;
        check(rqm == 1 && dio == 1, "R4", "read rqm/dio", {rqm, dio}, 2'b11);
        configure(1, 4'd4);
        start_exec(1);
        check(rqm == 0, "R5", "flushed rqm", rqm, 0);

        // R2 R6 R7: random read-direction traffic, threshold 4
        for (int i = 0; i < 400; i++) begin
            bit p, r;
            p = ($urandom % 2 == 1) && mq.size() < 16;
            r = ($urandom % 2 == 1) && mq.size() > 0;
            if (mq.size() > 0) check(host_rdata == mq[0], "R6", "read head", host_rdata, mq[0]);
            check(dma_req == exp_dma(1, mq.size(), 4), "R7", "read dma", dma_req, exp_dma(1, mq.size(), 4));
            check(rqm == (mq.size() > 0), "R4", "read rqm", rqm, mq.size() > 0);
            dsk_put = p; host_rd = r; dsk_in = 8'($urandom);
            cyc();
            if (r) void'(mq.pop_front());
            if (p) mq.push_back(dsk_in);
        end
        idle();

        // R6 R7: random write-direction traffic, threshold 9
        configure(1, 4'd9);
        start_exec(0);
        for (int i = 0; i < 400; i++) begin
            bit w, t;
            logic [7:0] e;
            w = ($urandom % 2 == 1) && mq.size() < 16;
            t = ($urandom % 2 == 1) && mq.size() > 0;
            check(dma_req == exp_dma(0, mq.size(), 9), "R7", "write dma", dma_req, exp_dma(0, mq.size(), 9));
            check(rqm == (mq.size() < 16), "R4", "write rqm", rqm, mq.size() < 16);
            host_wr = w; dsk_take = t; host_wdata = 8'($urandom);
            e = t ? mq[0] : 8'h00;
            cyc();
            if (t) begin
                void'(mq.pop_front());
                check(dsk_out == e, "R6", "disk byte", dsk_out, e);
            end
            if (w) mq.push_back(host_wdata);
        end
        idle();

        // R8: overrun at exactly 16 + 1
        configure(1, 4'd8);
        start_exec(1);
        for (int i = 0; i < 16; i++) begin
            dsk_put = 1; dsk_in = 8'(i * 7 + 1); mq.push_back(dsk_in); cyc();
        end
        check(dma_req == 1 && overrun == 0, "R8", "full no error", {dma_req, overrun}, 2'b10);
        dsk_in = 8'hEE; cyc();
        check(overrun == 1 && cmd_abort == 1, "R8", "overrun flag", {overrun, cmd_abort}, 2'b11);
        check(dma_req == 0 && rqm == 1, "R8", "dma off rqm on", {dma_req, rqm}, 2'b01);
        dsk_in = 8'hDD; cyc(); dsk_put = 0;
        check(cmd_abort == 0, "R8", "abort single", cmd_abort, 0);
        check(result_ready == 0, "R8", "not drained", result_ready, 0);
        for (int i = 0; i < 16; i++) begin
            check(host_rdata == mq[i], "R8", "drain data", host_rdata, mq[i]);
            host_rd = 1; cyc();
        end
        host_rd = 0;
        check(result_ready == 1 && rqm == 0, "R8", "result ready", {result_ready, rqm}, 2'b10);

        // R9 R10: write underrun and sector padding
        configure(1, 4'd4);
        start_exec(0);
        host_wr = 1; host_wdata = 8'h11; cyc();
        host_wdata = 8'h22; cyc(); host_wr = 0;
        dsk_take = 1; cyc();
        check(dsk_out == 8'h11, "R6", "take 1", dsk_out, 8'h11);
        cyc();
        check(dsk_out == 8'h22, "R6", "take 2", dsk_out, 8'h22);
        cyc();
        check(dsk_out == 8'h00 && underrun == 1 && cmd_abort == 1, "R9", "underrun", {dsk_out, underrun, cmd_abort}, 2'b11);
        check(pad_active == 1 && rqm == 0 && dma_req == 0, "R9", "pad stop", {pad_active, rqm, dma_req}, 3'b100);
        dsk_take = 0; host_wr = 1; host_wdata = 8'h99; cyc(); host_wr = 0;
        dsk_take = 1; cyc(); dsk_take = 0;
        check(dsk_out == 8'h00, "R9", "host write ignored", dsk_out, 0);
        sector_end = 1; cyc(); sector_end = 0;
        check(crc_append == 1 && pad_active == 0, "R10", "crc request", {crc_append, pad_active}, 2'b10);
        cyc();
        check(crc_append == 0, "R10", "crc single", crc_append, 0);
        start_exec(0);
        check(underrun == 0 && rqm == 1, "R5", "flags cleared", {underrun, rqm}, 2'b01);

        // R2: threshold 0 acts as 1
        configure(1, 4'd0);
        start_exec(1);
        check(dma_req == 0, "R2", "empty no dma", dma_req, 0);
        dsk_put = 1; dsk_in = 8'h42; cyc(); dsk_put = 0;
        check(dma_req == 1, "R2", "thr0 as 1", dma_req, 1);

        // R11: latency monitor, 2 Mbps, threshold 1 -> 250 clocks
        rate_sel = 2'b10;
        configure(1, 4'd1);
        start_exec(0);
        repeat (240) cyc();
        check(latency_viol == 0, "R11", "before limit", latency_viol, 0);
        repeat (20) cyc();
        check(latency_viol == 1, "R11", "after limit", latency_viol, 1);
        // R11: 1 Mbps, threshold 1 -> 650 clocks
        rate_sel = 2'b01;
        start_exec(0);
        check(latency_viol == 0, "R5", "viol cleared", latency_viol, 0);
        repeat (600) cyc();
        check(latency_viol == 0, "R11", "1M before limit", latency_viol, 0);
        repeat (60) cyc();
        check(latency_viol == 1, "R11", "1M after limit", latency_viol, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule